// File: doc/BRIEF.md
# Thread Block Admission Dispatcher

This block places incoming thread blocks onto a small array of multiprocessors. Each launch request carries a thread count and a per-thread register count. It arrives on a valid/ready handshake. A block goes to a multiprocessor only as a whole, and only when that multiprocessor has a free block slot, enough thread capacity and enough registers left in its register file. When the dispatcher places a block, it reports the chosen multiprocessor, a block ID, the number of 32-thread warps and the base of the register range it handed out.

The search is round-robin and starts at the multiprocessor after the last one that received a block. If no multiprocessor can take the request, the request stalls with ready low until a completion frees room. Requests that no multiprocessor could ever hold are taken at once and flagged as rejected. A completion notice names a multiprocessor and a block ID and gives back that block's slot and threads. Registers come from a bump pointer for each multiprocessor. The pointer returns to zero when its multiprocessor has no resident blocks.

Top module: `block_dispatch`

## Requirements
- R1: `reqReady` is high only while `reqValid` is high. Each cycle with `reqReady` high gives, in the next cycle, exactly one of `asgValid` or `rejValid` high for one cycle. Without an acceptance neither strobe rises.
- R2: A multiprocessor holds at most 8 resident blocks. A new block takes the lowest free slot index (0 to 7), and that index is reported as `asgBlock`.
- R3: A block is placed on a multiprocessor only if the resident thread total plus the request's threads is at most 768.
- R4: The register demand is threads × registers per thread. A block is placed only if the multiprocessor's register pointer plus the demand is at most 8192. `asgRegBase` is the pointer value before placement, and the pointer then advances by the demand.
- R5: `asgWarps` equals ceil(threads / 32).
- R6: A request with 0 threads, with more than 512 threads, or with a register demand above 8192 is accepted in the same cycle and reported with `rejValid` in the next cycle. It changes no multiprocessor state.
- R7: The candidates are searched starting at the multiprocessor after the last one that received a block, wrapping around, and the first one that passes R2–R4 wins. After reset the search starts at multiprocessor 0. If none passes, `reqReady` stays low.
- R8: A completion (`doneValid`, `doneSm`, `doneBlock`) frees that block's slot and threads for decisions from the next cycle on. Registers are reclaimed only when the multiprocessor has no resident blocks left, which resets its pointer to 0.
- R9: When a completion and an acceptance fall in the same cycle, the decision uses the state before the completion. A block placed on the same multiprocessor gets the old pointer as its base, and that pointer does not reset.
- R10: During reset and right after it, `reqReady`, `asgValid` and `rejValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Launch request present |
| reqReady | output | 1 | Request taken (placed or rejected) this cycle |
| reqThreads | input | 10 | Threads in the requested block |
| reqRegsPerThread | input | 6 | Registers each thread needs |
| doneValid | input | 1 | Completion notice present |
| doneSm | input | 2 | Multiprocessor of the completed block |
| doneBlock | input | 3 | Block ID of the completed block |
| asgValid | output | 1 | One-cycle placement strobe |
| asgSm | output | 2 | Multiprocessor chosen |
| asgBlock | output | 3 | Block ID (slot index) given |
| asgWarps | output | 5 | Warp count of the placed block |
| asgRegBase | output | 14 | First register of the block's range |
| rejValid | output | 1 | One-cycle rejection strobe |

## Verification
The assertions assume that a request holds its fields stable while it waits with ready low. They also assume that at most one completion arrives per cycle and that it only names a block that is resident at that time. The bench keeps to these assumptions because its model tracks every resident block in a queue: a completion is taken from that queue, and a request is held unchanged until the model sees it accepted. Under those conditions the checker checks that the stored thread totals and register pointers never pass their limits, and that each acceptance yields exactly one result strobe.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  // Strobes sent from control to datapath for the current cycle
  typedef struct packed {
    logic grant;   // place the request on the picked multiprocessor
    logic reject;  // consume the request as impossible
  } admitStrobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/dispatch_ctrl.sv
module dispatch_ctrl
  import dispatch_pkg::*;
#(
  parameter int NUM_SM            = 4,
  parameter int MAX_BLOCK_THREADS = 512,
  parameter int NUM_REGS          = 8192,
  parameter int THR_W             = 10,
  parameter int NEED_W            = 16,
  parameter int SM_W              = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [THR_W-1:0]  reqThreads,
  input  logic [NEED_W-1:0] reqNeed,
  input  logic [NUM_SM-1:0] fitVec,
  output logic              reqReady,
  output admitStrobe_t      strobe,
  output logic [SM_W-1:0]   pickSm
);
  logic [SM_W-1:0] lastSm;
  logic [SM_W-1:0] probeSm;
  logic            anyFit;
  logic            badReq;

  assign badReq = (reqThreads == '0)
               || (reqThreads > THR_W'(MAX_BLOCK_THREADS))
               || ({1'b0, reqNeed} > (NEED_W+1)'(NUM_REGS));

  // Rotating first-fit search, starting after the last multiprocessor used
  always_comb begin
    anyFit  = 1'b0;
    pickSm  = lastSm;
    probeSm = lastSm;
    for (int k = 0; k < NUM_SM; k++) begin
      probeSm = SM_W'((int'(lastSm) + 1 + k) % NUM_SM);
      if (!anyFit && fitVec[probeSm]) begin
        anyFit = 1'b1;
        pickSm = probeSm;
      end
    end
  end

  assign strobe.grant  = reqValid && !badReq && anyFit;
  assign strobe.reject = reqValid && badReq;
  assign reqReady      = strobe.grant || strobe.reject;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             lastSm <= SM_W'(NUM_SM - 1);
    else if (strobe.grant) lastSm <= pickSm;
  end
endmodule

// File: rtl/dispatch_datapath.sv
module dispatch_datapath
  import dispatch_pkg::*;
#(
  parameter int NUM_SM      = 4,
  parameter int MAX_BLOCKS  = 8,
  parameter int MAX_THREADS = 768,
  parameter int NUM_REGS    = 8192,
  parameter int WARP        = 32,
  parameter int THR_W       = 10,
  parameter int RPT_W       = 6,
  parameter int SM_W        = 2,
  parameter int BLK_W       = 3,
  parameter int OCC_W       = 10,
  parameter int REG_W       = 14,
  parameter int NEED_W      = 16,
  parameter int WARP_W      = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [THR_W-1:0]        reqThreads,
  input  logic [RPT_W-1:0]        reqRegsPerThread,
  input  logic                    doneValid,
  input  logic [SM_W-1:0]         doneSm,
  input  logic [BLK_W-1:0]        doneBlock,
  input  admitStrobe_t            strobe,
  input  logic [SM_W-1:0]         pickSm,
  output logic [NUM_SM-1:0]       fitVec,
  output logic [NEED_W-1:0]       reqNeed,
  output logic [NUM_SM*OCC_W-1:0] thrUsedFlat,
  output logic [NUM_SM*REG_W-1:0] regPtrFlat,
  output logic                    asgValid,
  output logic [SM_W-1:0]         asgSm,
  output logic [BLK_W-1:0]        asgBlock,
  output logic [WARP_W-1:0]       asgWarps,
  output logic [REG_W-1:0]        asgRegBase,
  output logic                    rejValid
);
  localparam int SUM_W  = ((OCC_W > THR_W) ? OCC_W : THR_W) + 1;
  localparam int RSUM_W = ((REG_W > NEED_W) ? REG_W : NEED_W) + 1;

  logic [NUM_SM*BLK_W-1:0] freeSlotFlat;
  logic [THR_W:0]          roundUp;
  logic [WARP_W-1:0]       warpCnt;

  assign reqNeed = NEED_W'(reqThreads) * NEED_W'(reqRegsPerThread);
  assign roundUp = (THR_W+1)'(reqThreads) + (THR_W+1)'(WARP - 1);
  assign warpCnt = WARP_W'(roundUp / (THR_W+1)'(WARP));

  for (genvar s = 0; s < NUM_SM; s++) begin : g_sm
    logic [MAX_BLOCKS-1:0] slotBits, bitsNext;
    logic [OCC_W-1:0]      thrUsed, thrNext;
    logic [REG_W-1:0]      regPtr, ptrNext;
    logic [THR_W-1:0]      slotThr [MAX_BLOCKS];
    logic [BLK_W-1:0]      freeIdx;
    logic [SUM_W-1:0]      thrSum;
    logic [RSUM_W-1:0]     regSum;
    logic                  doneHit, takeHit;

    always_comb begin
      freeIdx = '0;
      for (int b = MAX_BLOCKS - 1; b >= 0; b--)
        if (!slotBits[b]) freeIdx = BLK_W'(b);
    end

    assign thrSum    = SUM_W'(thrUsed) + SUM_W'(reqThreads);
    assign regSum    = RSUM_W'(regPtr) + RSUM_W'(reqNeed);
    assign fitVec[s] = !(&slotBits)
                    && (thrSum <= SUM_W'(MAX_THREADS))
                    && (regSum <= RSUM_W'(NUM_REGS));

    assign doneHit = doneValid && (doneSm == SM_W'(s)) && slotBits[doneBlock];
    assign takeHit = strobe.grant && (pickSm == SM_W'(s));

    always_comb begin
      bitsNext = slotBits;
      thrNext  = thrUsed;
      ptrNext  = regPtr;
      if (doneHit) begin
        bitsNext[doneBlock] = 1'b0;
        thrNext = thrNext - OCC_W'(slotThr[doneBlock]);
      end
      if (takeHit) begin
        bitsNext[freeIdx] = 1'b1;
        thrNext = thrNext + OCC_W'(reqThreads);
        ptrNext = ptrNext + REG_W'(reqNeed);
      end
      if (bitsNext == '0) ptrNext = '0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotBits <= '0;
        thrUsed  <= '0;
        regPtr   <= '0;
        for (int b = 0; b < MAX_BLOCKS; b++) slotThr[b] <= '0;
      end else begin
        slotBits <= bitsNext;
        thrUsed  <= thrNext;
        regPtr   <= ptrNext;
        if (takeHit) slotThr[freeIdx] <= reqThreads;
      end
    end

    assign thrUsedFlat[s*OCC_W +: OCC_W]  = thrUsed;
    assign regPtrFlat[s*REG_W +: REG_W]   = regPtr;
    assign freeSlotFlat[s*BLK_W +: BLK_W] = freeIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asgValid   <= 1'b0;
      rejValid   <= 1'b0;
      asgSm      <= '0;
      asgBlock   <= '0;
      asgWarps   <= '0;
      asgRegBase <= '0;
    end else begin
      asgValid <= strobe.grant;
      rejValid <= strobe.reject;
      if (strobe.grant) begin
        asgSm      <= pickSm;
        asgBlock   <= freeSlotFlat[int'(pickSm)*BLK_W +: BLK_W];
        asgWarps   <= warpCnt;
        asgRegBase <= regPtrFlat[int'(pickSm)*REG_W +: REG_W];
      end
    end
  end
endmodule

// File: rtl/block_dispatch.sv
module block_dispatch
  import dispatch_pkg::*;
#(
  parameter int NUM_SM            = 4,
  parameter int MAX_BLOCKS        = 8,
  parameter int MAX_THREADS       = 768,
  parameter int MAX_BLOCK_THREADS = 512,
  parameter int NUM_REGS          = 8192,
  parameter int WARP              = 32,
  parameter int RPT_W             = 6,
  localparam int SM_W   = (NUM_SM > 1) ? $clog2(NUM_SM) : 1,
  localparam int BLK_W  = (MAX_BLOCKS > 1) ? $clog2(MAX_BLOCKS) : 1,
  localparam int THR_W  = $clog2(MAX_BLOCK_THREADS + 1),
  localparam int REG_W  = $clog2(NUM_REGS + 1),
  localparam int WARP_W = $clog2(ceilDiv(MAX_BLOCK_THREADS, WARP) + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [THR_W-1:0]  reqThreads,
  input  logic [RPT_W-1:0]  reqRegsPerThread,
  input  logic              doneValid,
  input  logic [SM_W-1:0]   doneSm,
  input  logic [BLK_W-1:0]  doneBlock,
  output logic              asgValid,
  output logic [SM_W-1:0]   asgSm,
  output logic [BLK_W-1:0]  asgBlock,
  output logic [WARP_W-1:0] asgWarps,
  output logic [REG_W-1:0]  asgRegBase,
  output logic              rejValid
);
  localparam int OCC_W  = $clog2(MAX_THREADS + 1);
  localparam int NEED_W = THR_W + RPT_W;

  admitStrobe_t            strobe;
  logic [SM_W-1:0]         pickSm;
  logic [NUM_SM-1:0]       fitVec;
  logic [NEED_W-1:0]       reqNeed;
  logic [NUM_SM*OCC_W-1:0] thrUsedFlat;
  logic [NUM_SM*REG_W-1:0] regPtrFlat;

  dispatch_ctrl #(
    .NUM_SM(NUM_SM), .MAX_BLOCK_THREADS(MAX_BLOCK_THREADS), .NUM_REGS(NUM_REGS),
    .THR_W(THR_W), .NEED_W(NEED_W), .SM_W(SM_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqThreads(reqThreads),
    .reqNeed(reqNeed), .fitVec(fitVec), .reqReady(reqReady),
    .strobe(strobe), .pickSm(pickSm)
  );

  dispatch_datapath #(
    .NUM_SM(NUM_SM), .MAX_BLOCKS(MAX_BLOCKS), .MAX_THREADS(MAX_THREADS),
    .NUM_REGS(NUM_REGS), .WARP(WARP), .THR_W(THR_W), .RPT_W(RPT_W),
    .SM_W(SM_W), .BLK_W(BLK_W), .OCC_W(OCC_W), .REG_W(REG_W),
    .NEED_W(NEED_W), .WARP_W(WARP_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .reqThreads(reqThreads),
    .reqRegsPerThread(reqRegsPerThread), .doneValid(doneValid),
    .doneSm(doneSm), .doneBlock(doneBlock), .strobe(strobe), .pickSm(pickSm),
    .fitVec(fitVec), .reqNeed(reqNeed), .thrUsedFlat(thrUsedFlat),
    .regPtrFlat(regPtrFlat), .asgValid(asgValid), .asgSm(asgSm),
    .asgBlock(asgBlock), .asgWarps(asgWarps), .asgRegBase(asgRegBase),
    .rejValid(rejValid)
  );
endmodule

// File: rtl/dispatch_checker.sv
module dispatch_checker #(
  parameter int NUM_SM            = 4,
  parameter int MAX_THREADS       = 768,
  parameter int MAX_BLOCK_THREADS = 512,
  parameter int NUM_REGS          = 8192,
  parameter int WARP              = 32,
  parameter int THR_W             = 10,
  parameter int OCC_W             = 10,
  parameter int REG_W             = 14,
  parameter int WARP_W            = 5
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    reqValid,
  input logic                    reqReady,
  input logic [THR_W-1:0]        reqThreads,
  input logic                    asgValid,
  input logic [WARP_W-1:0]       asgWarps,
  input logic                    rejValid,
  input logic [NUM_SM*OCC_W-1:0] thrUsedFlat,
  input logic [NUM_SM*REG_W-1:0] regPtrFlat
);
  logic badSize;
  assign badSize = (reqThreads == '0) || (reqThreads > THR_W'(MAX_BLOCK_THREADS));

  p_ready_needs_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> reqValid);

  p_one_result_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> (asgValid != rejValid));

  p_no_spurious_result_r1: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |=> (!asgValid && !rejValid));

  p_bad_size_taken_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && badSize) |-> reqReady);

  p_bad_size_flagged_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && badSize) |=> rejValid);

  p_warp_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    asgValid |-> (asgWarps != '0) && (asgWarps <= WARP_W'(MAX_BLOCK_THREADS / WARP)));

  for (genvar s = 0; s < NUM_SM; s++) begin : g_cap
    p_thread_cap_r3: assert property (@(posedge clk) disable iff (!rstN)
      thrUsedFlat[s*OCC_W +: OCC_W] <= OCC_W'(MAX_THREADS));
    p_reg_cap_r4: assert property (@(posedge clk) disable iff (!rstN)
      regPtrFlat[s*REG_W +: REG_W] <= REG_W'(NUM_REGS));
  end
endmodule

bind block_dispatch dispatch_checker #(
  .NUM_SM(NUM_SM), .MAX_THREADS(MAX_THREADS), .MAX_BLOCK_THREADS(MAX_BLOCK_THREADS),
  .NUM_REGS(NUM_REGS), .WARP(WARP), .THR_W(THR_W), .OCC_W(OCC_W),
  .REG_W(REG_W), .WARP_W(WARP_W)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqThreads(reqThreads), .asgValid(asgValid), .asgWarps(asgWarps),
  .rejValid(rejValid), .thrUsedFlat(thrUsedFlat), .regPtrFlat(regPtrFlat)
);

// File: tb/tb_block_dispatch.sv
`timescale 1ns/1ps
module tb_block_dispatch;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqReady;
  logic [9:0] reqThreads = '0;
  logic [5:0] reqRegsPerThread = '0;
  logic       doneValid = 1'b0;
  logic [1:0] doneSm = '0;
  logic [2:0] doneBlock = '0;
  logic       asgValid, rejValid;
  logic [1:0] asgSm;
  logic [2:0] asgBlock;
  logic [4:0] asgWarps;
  logic [13:0] asgRegBase;

  block_dispatch dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqThreads(reqThreads), .reqRegsPerThread(reqRegsPerThread),
    .doneValid(doneValid), .doneSm(doneSm), .doneBlock(doneBlock),
    .asgValid(asgValid), .asgSm(asgSm), .asgBlock(asgBlock),
    .asgWarps(asgWarps), .asgRegBase(asgRegBase), .rejValid(rejValid)
  );

  always #2.5 clk = ~clk;

  int tests = 0;
  int fails = 0;

  // Behavioural reference model
  bit [7:0] mBits [4];
  int mThr [4];
  int mPtr [4];
  int mSlotThr [4][8];
  int mLast = 3;
  int resSm [$];
  int resBlk [$];
  bit eAsg, eRej, accepted;
  int eSm, eBlk, eWarps, eBase;

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Called just after a negedge with inputs set; returns at the next negedge
  task automatic step();
    int thr, need, fit, slot;
    bit bad, grant, rej;
    #1;
    thr  = int'(reqThreads);
    need = thr * int'(reqRegsPerThread);
    bad  = (thr == 0) || (thr > 512) || (need > 8192);
    fit  = -1;
    slot = 0;
    if (!bad)
      for (int k = 0; k < 4; k++) begin
        int s;
        s = (mLast + 1 + k) % 4;
        if (fit < 0 && mBits[s] != 8'hFF && mThr[s] + thr <= 768 && mPtr[s] + need <= 8192)
          fit = s;
      end
    grant = reqValid && !bad && (fit >= 0);
    rej   = reqValid && bad;
    check("R1/R7 ready", int'(reqReady), int'(grant || rej));
    @(posedge clk);
    eAsg = grant;
    eRej = rej;
    if (grant) begin
      while (mBits[fit][slot]) slot++;
      eSm = fit; eBlk = slot; eWarps = (thr + 31) / 32; eBase = mPtr[fit];
    end
    if (doneValid) begin
      mBits[doneSm][doneBlock] = 1'b0;
      mThr[doneSm] -= mSlotThr[doneSm][doneBlock];
    end
    if (grant) begin
      mBits[fit][slot] = 1'b1;
      mThr[fit] += thr;
      mPtr[fit] += need;
      mSlotThr[fit][slot] = thr;
      mLast = fit;
      resSm.push_back(fit);
      resBlk.push_back(slot);
    end
    for (int s = 0; s < 4; s++) if (mBits[s] == 8'h00) mPtr[s] = 0;
    accepted = grant || rej;
    @(negedge clk);
    check("R1 placement strobe", int'(asgValid), int'(eAsg));
    check("R6 reject strobe", int'(rejValid), int'(eRej));
    if (eAsg) begin
      check("R7 multiprocessor", int'(asgSm), eSm);
      check("R2 block id", int'(asgBlock), eBlk);
      check("R5 warp count", int'(asgWarps), eWarps);
      check("R4 register base", int'(asgRegBase), eBase);
    end
  endtask

  task automatic send(input int thr, input int rpt, input int cap, output bit ok);
    reqValid = 1'b1;
    reqThreads = 10'(thr);
    reqRegsPerThread = 6'(rpt);
    ok = 1'b0;
    for (int c = 0; c < cap && !ok; c++) begin
      step();
      ok = accepted;
    end
    reqValid = 1'b0;
  endtask

  task automatic completeAt(input int i);
    doneValid = 1'b1;
    doneSm = 2'(resSm[i]);
    doneBlock = 3'(resBlk[i]);
    resSm.delete(i);
    resBlk.delete(i);
    step();
    doneValid = 1'b0;
  endtask

  function automatic int findSm(input int sm);
    foreach (resSm[i]) if (resSm[i] == sm) return i;
    return -1;
  endfunction

  task automatic drain();
    reqValid = 1'b0;
    while (resSm.size() > 0) completeAt(0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit ok;
    int a;
    foreach (mBits[s]) begin mBits[s] = '0; mThr[s] = 0; mPtr[s] = 0; end
    repeat (3) @(negedge clk);
    // R10: outputs quiet in reset
    check("R10 ready in reset", int'(reqReady), 0);
    check("R10 placement in reset", int'(asgValid), 0);
    check("R10 reject in reset", int'(rejValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    step();
    check("R10 quiet after reset", int'(asgValid | rejValid), 0);

    // Three 256-thread, 10-register blocks fill each multiprocessor
    for (int i = 0; i < 12; i++) begin
      send(256, 10, 2, ok);
      check("R7 round-robin placement accepted", int'(ok), 1);
    end
    send(256, 10, 3, ok);
    check("R3 full multiprocessors stall the request", int'(ok), 0);
    reqValid = 1'b1;
    completeAt(findSm(0));
    step();
    check("R8 registers held while blocks remain", int'(accepted), 0);
    completeAt(findSm(0));
    completeAt(findSm(0));
    step();
    check("R8 placement after multiprocessor emptied", int'(accepted), 1);
    check("R8 pointer reset gives base 0", int'(asgRegBase), 0);
    check("R8 emptied multiprocessor chosen", int'(asgSm), 0);
    drain();

    // 11 registers per thread: only two 256-thread blocks fit per multiprocessor
    for (int i = 0; i < 8; i++) send(256, 11, 2, ok);
    send(256, 11, 3, ok);
    check("R4 register file limits to two blocks", int'(ok), 0);
    drain();

    // Tiny blocks: block slot limit
    for (int i = 0; i < 32; i++) send(16, 0, 2, ok);
    check("R2 highest slot index used", int'(asgBlock), 7);
    send(16, 0, 3, ok);
    check("R2 ninth block on every multiprocessor stalls", int'(ok), 0);
    drain();

    // Rejections and warp boundaries
    send(0, 1, 1, ok);
    check("R6 zero-thread request consumed", int'(ok), 1);
    send(513, 0, 1, ok);
    check("R6 oversize request consumed", int'(ok), 1);
    send(512, 17, 1, ok);
    check("R6 register demand above file consumed", int'(ok), 1);
    send(32, 1, 1, ok);
    check("R6 rejects left pointer untouched", int'(asgRegBase), 0);
    check("R5 one full warp", int'(asgWarps), 1);
    send(33, 0, 1, ok);
    check("R5 partial second warp", int'(asgWarps), 2);
    send(512, 16, 1, ok);
    check("R4 exact register fill accepted", int'(ok), 1);
    check("R5 largest block warps", int'(asgWarps), 16);
    drain();

    // R9: completion and placement on the same multiprocessor in one cycle
    a = (mLast + 1) % 4;
    for (int i = 0; i < 4; i++) send(32, 1, 1, ok);
    reqValid = 1'b1;
    reqThreads = 10'd64;
    reqRegsPerThread = 6'd2;
    completeAt(findSm(a));
    reqValid = 1'b0;
    check("R9 same-cycle placement accepted", int'(asgValid), 1);
    check("R9 placed on completing multiprocessor", int'(asgSm), a);
    check("R9 base keeps old pointer", int'(asgRegBase), 32);
    drain();

    // Mixed traffic with completions
    for (int i = 0; i < 400; i++) begin
      if (!reqValid && ($urandom % 2 == 0)) begin
        reqValid = 1'b1;
        reqThreads = 10'($urandom % 600);
        reqRegsPerThread = 6'($urandom % 20);
      end
      if (resSm.size() > 0 && ($urandom % 3 == 0)) begin
        doneValid = 1'b1;
        a = int'($urandom % resSm.size());
        doneSm = 2'(resSm[a]);
        doneBlock = 3'(resBlk[a]);
        resSm.delete(a);
        resBlk.delete(a);
      end
      step();
      doneValid = 1'b0;
      if (accepted) reqValid = 1'b0;
    end
    drain();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule